// File: doc/BRIEF.md
# Programming-Track Command Sequencer

This block drives one direct-addressed configuration transaction on an isolated programming track. A host gives a configuration variable number (1 to 1024), a data byte, a bit index, and two flags. One flag picks write or verify. The other picks single-bit or whole-byte access. The host then pulses `start`. The sequencer sends a stream of packet requests to a downstream bit serializer over a valid/ready handshake. Each request carries up to four packet bytes, a byte count and a preamble length.

The stream has a fixed order:
- An optional warm-up run of reset packets.
- A lead-in of reset packets.
- A burst of identical instruction packets.
- For writes, a further run of identical write packets that covers the decoder's recovery time.
- A short trailer of reset packets.

The block listens to an acknowledge-detect input only while the acknowledge window is open. An acknowledge cuts the current burst short, and the block goes straight to the trailer. During warm-up, a load-current fault that is still present once the settling timer has expired aborts the transaction and raises an over-current flag.

Top module: `svc_prog_seq`

## Requirements
- R1: Every requested packet carries a preamble length of at least 20 bits.
- R2: With `pwr_phase` high at start, at least `PWRON_PKTS` (20) reset packets are accepted before the lead-in. When `pkt_ready` is held high, exactly 20 are accepted, provided the settling timer expires first.
- R3: A transaction sends `RESET_PKTS` (3) reset packets, then `INSTR_PKTS` (5) identical instruction packets, then `TAIL_PKTS` (1) reset packet. After that, `done` is high for one cycle.
- R4: A byte or bit write adds `RECOV_PKTS` (6) copies of the same write packet between the instruction burst and the trailer. A verify adds none.
- R5: An instruction packet is four bytes, with byte 0 in `pkt_bytes[31:24]`. Let A = CV number − 1 (10 bits).
  - Byte 0 is `0111 CC A[9:8]`, where CC is 01 for byte verify, 11 for byte write and 10 for bit access.
  - Byte 1 is A[7:0].
  - Byte 3 is the XOR of bytes 0 to 2.
  - A reset packet has length 3 and all bytes zero.
- R6: `ack_in` is captured into `ack_seen` only in two places. The first is the instruction burst, after the second instruction packet has been accepted. The second is the recovery run. An acknowledge at any other time leaves `ack_seen` low.
- R7: After an acknowledge is captured, the current burst (instruction or recovery) ends at its next accepted packet. Recovery is skipped, and the trailer follows.
- R8: During warm-up, `fault_in` is ignored until `FAULT_CYCLES` cycles have passed. If it is high after that, `pkt_valid` drops, `overcurrent` rises and `done` pulses.
- R9: While `pkt_valid` is high and `pkt_ready` is low, the packet fields hold steady. Only an accepted packet counts toward a phase total.
- R10: A start whose CV number is 0 or above 1024 is ignored. The block stays idle with `pkt_valid` low.
- R11: `ack_seen` and `overcurrent` hold their values after `done` until the next accepted start.
- R12: In bit access, byte 2 is `111 K D BBB`. K is 1 for write and 0 for verify, D is `wr_data[0]`, and BBB is `bit_sel`. In byte access, byte 2 is `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| op_write | input | 1 | 1 = write, 0 = verify |
| bit_mode | input | 1 | 1 = single-bit access, 0 = byte access |
| cv_num | input | 11 | Configuration variable number, 1 to 1024 |
| wr_data | input | 8 | Data byte, or bit value in bit 0 |
| bit_sel | input | 3 | Bit index for bit access |
| pwr_phase | input | 1 | Run the warm-up reset phase first |
| ack_in | input | 1 | Acknowledge pulse detected on the track |
| fault_in | input | 1 | Load current above the fault limit |
| pkt_ready | input | 1 | Serializer accepts the offered packet |
| pkt_valid | output | 1 | Packet offered |
| pkt_bytes | output | 32 | Packet bytes, first byte in the top octet |
| pkt_len | output | 3 | Byte count, 3 or 4 |
| pkt_preamble | output | 6 | Preamble length in bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ack_seen | output | 1 | Acknowledge captured in the window |
| overcurrent | output | 1 | Transaction aborted on sustained fault |

## Verification
The properties assume a few things about the environment:
- `ack_in` and `fault_in` are synchronous single-bit levels.
- The serializer may stall `pkt_ready` for any number of cycles.
- A new `start` is ignored while a transaction runs.

The stimulus raises acknowledges only at negative edges. It holds `pkt_ready` low across each injected acknowledge, so the cycle in which the burst ends is fixed. Faults are raised either briefly inside the settling time or steadily from the start of warm-up.

// File: rtl/svc_prog_pkg.sv
package svc_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRON,
    ST_RST,
    ST_INSTR,
    ST_RECOV,
    ST_TAIL,
    ST_DONE
  } seq_st_t;

  localparam int PKT_BYTES = 4;
  localparam int PKT_W     = 8 * PKT_BYTES;

  localparam logic [3:0] DIRECT_TAG = 4'b0111;
  localparam logic [1:0] CC_VERIFY  = 2'b01;
  localparam logic [1:0] CC_BIT     = 2'b10;
  localparam logic [1:0] CC_WRITE   = 2'b11;

endpackage

// File: rtl/svc_pkt_build.sv
module svc_pkt_build
  import svc_prog_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic             is_write,
  input  logic             bit_mode,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       data,
  input  logic [2:0]       bit_sel,
  output logic [PKT_W-1:0] bytes
);

  localparam int HDR_N = PKT_BYTES - 1;

  logic [7:0] hdr [HDR_N];
  logic [1:0] cc;
  logic [7:0] csum;

  // Instruction class and header bytes
  always_comb begin
    if (bit_mode)      cc = CC_BIT;
    else if (is_write) cc = CC_WRITE;
    else               cc = CC_VERIFY;

    hdr[0] = {DIRECT_TAG, cc, addr[AW-1:AW-2]};
    hdr[1] = addr[7:0];
    hdr[2] = bit_mode ? {3'b111, is_write, data[0], bit_sel} : data;
  end

  // Error-detection byte over all header bytes
  always_comb begin
    csum = '0;
    for (int i = 0; i < HDR_N; i++) csum = csum ^ hdr[i];
  end

  for (genvar g = 0; g < PKT_BYTES; g++) begin : g_pack
    if (g < HDR_N) begin : g_hdr
      assign bytes[PKT_W-1-8*g -: 8] = hdr[g];
    end else begin : g_cs
      assign bytes[PKT_W-1-8*g -: 8] = csum;
    end
  end

endmodule

// File: rtl/svc_phase_ctl.sv
module svc_phase_ctl
  import svc_prog_pkg::*;
#(
  parameter int PWRON_PKTS = 20,
  parameter int RESET_PKTS = 3,
  parameter int INSTR_PKTS = 5,
  parameter int RECOV_PKTS = 6,
  parameter int TAIL_PKTS  = 1,
  parameter int CNT_MAX    = 20,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             pwr_req,
  input  logic             is_write,
  input  logic             acc,
  input  logic             ack_seen,
  input  logic             tmr_done,
  input  logic             fault_in,
  output seq_st_t          st,
  output logic [CNT_W-1:0] cnt
);

  seq_st_t          st_n;
  logic [CNT_W-1:0] cnt_n;

  // Next-state logic
  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE:  if (start_ok) st_n = pwr_req ? ST_PWRON : ST_RST;
      ST_PWRON: begin
        if (tmr_done && fault_in)
          st_n = ST_DONE;
        else if (acc && tmr_done && cnt >= CNT_W'(PWRON_PKTS - 1))
          st_n = ST_RST;
      end
      ST_RST:   if (acc && cnt == CNT_W'(RESET_PKTS - 1)) st_n = ST_INSTR;
      ST_INSTR: begin
        if (acc && (ack_seen || cnt == CNT_W'(INSTR_PKTS - 1)))
          st_n = (is_write && !ack_seen) ? ST_RECOV : ST_TAIL;
      end
      ST_RECOV: begin
        if (acc && (ack_seen || cnt == CNT_W'(RECOV_PKTS - 1)))
          st_n = ST_TAIL;
      end
      ST_TAIL:  if (acc && cnt == CNT_W'(TAIL_PKTS - 1)) st_n = ST_DONE;
      ST_DONE:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase

    // Packet counter restarts at each phase change
    cnt_n = cnt;
    if (st_n != st)
      cnt_n = '0;
    else if (acc && cnt != CNT_W'(CNT_MAX))
      cnt_n = cnt + CNT_W'(1);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/svc_ack_guard.sv
module svc_ack_guard
  import svc_prog_pkg::*;
#(
  parameter int FAULT_CYCLES = 12_500_000,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_t          st,
  input  logic [CNT_W-1:0] cnt,
  input  logic             start_ok,
  input  logic             ack_in,
  input  logic             fault_in,
  output logic             ack_seen,
  output logic             overcurrent,
  output logic             tmr_done
);

  localparam int TW = $clog2(FAULT_CYCLES + 1);

  logic [TW-1:0] tmr;
  logic          tmr_en;
  logic          win_open;
  logic          ack_set;
  logic          ovc_set;

  // Window opens once the second instruction packet has gone out
  always_comb begin
    win_open = (st == ST_INSTR && cnt >= CNT_W'(2)) || (st == ST_RECOV);
    ack_set  = win_open && ack_in;
    tmr_done = (tmr == TW'(FAULT_CYCLES));
    tmr_en   = (st == ST_PWRON) && !tmr_done;
    ovc_set  = (st == ST_PWRON) && tmr_done && fault_in;
  end

  // Settling timer for the warm-up phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmr <= '0;
    else if (start_ok) tmr <= '0;
    else if (tmr_en)   tmr <= tmr + TW'(1);
  end

  // Result flags, held until the next transaction starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_seen    <= 1'b0;
      overcurrent <= 1'b0;
    end else if (start_ok) begin
      ack_seen    <= 1'b0;
      overcurrent <= 1'b0;
    end else begin
      if (ack_set) ack_seen    <= 1'b1;
      if (ovc_set) overcurrent <= 1'b1;
    end
  end

endmodule

// File: rtl/svc_prog_seq.sv
module svc_prog_seq
  import svc_prog_pkg::*;
#(
  parameter int PREAMBLE_BITS = 22,
  parameter int PWRON_PKTS    = 20,
  parameter int RESET_PKTS    = 3,
  parameter int INSTR_PKTS    = 5,
  parameter int RECOV_PKTS    = 6,
  parameter int TAIL_PKTS     = 1,
  parameter int FAULT_CYCLES  = 12_500_000,
  parameter int CV_MAX        = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_write,
  input  logic        bit_mode,
  input  logic [10:0] cv_num,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  bit_sel,
  input  logic        pwr_phase,
  input  logic        ack_in,
  input  logic        fault_in,
  input  logic        pkt_ready,
  output logic        pkt_valid,
  output logic [31:0] pkt_bytes,
  output logic [2:0]  pkt_len,
  output logic [5:0]  pkt_preamble,
  output logic        busy,
  output logic        done,
  output logic        ack_seen,
  output logic        overcurrent
);

  localparam int CVW   = $clog2(CV_MAX + 1);
  localparam int AW    = $clog2(CV_MAX);
  localparam int M1    = (PWRON_PKTS > RESET_PKTS) ? PWRON_PKTS : RESET_PKTS;
  localparam int M2    = (INSTR_PKTS > RECOV_PKTS) ? INSTR_PKTS : RECOV_PKTS;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int CNT_MAX = (M3 > TAIL_PKTS) ? M3 : TAIL_PKTS;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             start_ok;
  logic             acc;
  logic             tmr_done;
  logic             long_pkt;
  logic [PKT_W-1:0] instr_bytes;

  logic             req_write;
  logic             req_bit;
  logic [AW-1:0]    req_addr;
  logic [7:0]       req_data;
  logic [2:0]       req_bitsel;

  always_comb begin
    start_ok = start && (st == ST_IDLE) && (cv_num != '0)
               && (cv_num <= CVW'(CV_MAX));
    pkt_valid = (st == ST_PWRON) || (st == ST_RST) || (st == ST_INSTR)
                || (st == ST_RECOV) || (st == ST_TAIL);
    long_pkt  = (st == ST_INSTR) || (st == ST_RECOV);
    acc       = pkt_valid && pkt_ready;
    pkt_bytes = long_pkt ? instr_bytes : '0;
    pkt_len   = long_pkt ? 3'd4 : 3'd3;
    pkt_preamble = 6'(PREAMBLE_BITS);
    busy      = (st != ST_IDLE);
    done      = (st == ST_DONE);
  end

  // Request capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_write  <= 1'b0;
      req_bit    <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
      req_bitsel <= '0;
    end else if (start_ok) begin
      req_write  <= op_write;
      req_bit    <= bit_mode;
      req_addr   <= AW'(cv_num - CVW'(1));
      req_data   <= wr_data;
      req_bitsel <= bit_sel;
    end
  end

  svc_pkt_build #(.AW(AW)) u_build (
    .is_write (req_write),
    .bit_mode (req_bit),
    .addr     (req_addr),
    .data     (req_data),
    .bit_sel  (req_bitsel),
    .bytes    (instr_bytes)
  );

  svc_phase_ctl #(
    .PWRON_PKTS (PWRON_PKTS),
    .RESET_PKTS (RESET_PKTS),
    .INSTR_PKTS (INSTR_PKTS),
    .RECOV_PKTS (RECOV_PKTS),
    .TAIL_PKTS  (TAIL_PKTS),
    .CNT_MAX    (CNT_MAX),
    .CNT_W      (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .pwr_req  (pwr_phase),
    .is_write (req_write),
    .acc      (acc),
    .ack_seen (ack_seen),
    .tmr_done (tmr_done),
    .fault_in (fault_in),
    .st       (st),
    .cnt      (cnt)
  );

  svc_ack_guard #(
    .FAULT_CYCLES (FAULT_CYCLES),
    .CNT_W        (CNT_W)
  ) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .cnt         (cnt),
    .start_ok    (start_ok),
    .ack_in      (ack_in),
    .fault_in    (fault_in),
    .ack_seen    (ack_seen),
    .overcurrent (overcurrent),
    .tmr_done    (tmr_done)
  );

endmodule

// File: rtl/svc_prog_seq_chk.sv
module svc_prog_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic [31:0] pkt_bytes,
  input logic [2:0]  pkt_len,
  input logic [5:0]  pkt_preamble,
  input logic        ack_in,
  input logic        ack_seen,
  input logic        fault_in,
  input logic        overcurrent,
  input logic        done,
  input logic        busy
);

  // R1
  a_r1_long_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> pkt_preamble >= 6'd20);

  // R5: four-byte packets end in the XOR of the first three
  a_r5_csum_long: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_len == 3'd4 |->
      pkt_bytes[7:0] == (pkt_bytes[31:24] ^ pkt_bytes[23:16] ^ pkt_bytes[15:8]));

  // R5: three-byte packets are broadcast resets
  a_r5_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_len == 3'd3 |-> pkt_bytes == 32'h0);

  // R9
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=>
      (pkt_valid && $stable(pkt_bytes) && $stable(pkt_len)) || overcurrent);

  // R6
  a_r6_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_seen) |-> $past(ack_in) && $past(busy));

  // R8
  a_r8_ovc_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overcurrent) |-> $past(fault_in) && !pkt_valid && done);

  // R3 / R11
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R10
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pkt_valid);

endmodule

bind svc_prog_seq svc_prog_seq_chk u_chk (.*);

// File: tb/sim_svc_prog_seq.sv
module sim_svc_prog_seq;

  localparam int FC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_write = 1'b0;
  logic        bit_mode = 1'b0;
  logic [10:0] cv_num = 11'd1;
  logic [7:0]  wr_data = 8'h00;
  logic [2:0]  bit_sel = 3'd0;
  logic        pwr_phase = 1'b0;
  logic        ack_in = 1'b0;
  logic        fault_in = 1'b0;
  logic        pkt_ready;
  logic        pkt_valid;
  logic [31:0] pkt_bytes;
  logic [2:0]  pkt_len;
  logic [5:0]  pkt_preamble;
  logic        busy, done, ack_seen, overcurrent;

  logic       ready_hold = 1'b0;
  logic       tog_mode = 1'b0;
  logic [1:0] tog = 2'd0;

  assign pkt_ready = !ready_hold && (!tog_mode || tog != 2'b10);

  always #4 clk = ~clk;

  svc_prog_seq #(.FAULT_CYCLES(FC)) u0 (.*);

  typedef struct {
    logic [31:0] b;
    logic [2:0]  len;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   n_long = 0;
  int   n_acc = 0;
  bit   loose = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit wr, input bit bm, input int cv,
                                     input logic [7:0] d, input int bp);
    logic [9:0] a;
    logic [1:0] cc;
    logic [7:0] b0, b1, b2;
    a  = 10'(cv - 1);
    cc = bm ? 2'b10 : (wr ? 2'b11 : 2'b01);
    b0 = {4'b0111, cc, a[9:8]};
    b1 = a[7:0];
    b2 = bm ? {3'b111, wr, d[0], 3'(bp)} : d;
    return {b0, b1, b2, b0 ^ b1 ^ b2};
  endfunction

  task automatic push(input int n, input logic [31:0] b, input logic [2:0] len);
    exp_t e;
    e.b = b;
    e.len = len;
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  always @(negedge clk) tog <= tog + 2'd1;

  // Monitor: every accepted packet is compared against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && pkt_valid && pkt_ready) begin
      exp_t e;
      n_acc++;
      if (pkt_len == 3'd4) n_long++;
      chk(pkt_preamble >= 6'd20, "R1 preamble", 64'(pkt_preamble), 64'd20);
      if (loose) begin
        chk(pkt_len == 3'd3 && pkt_bytes == 32'h0, "R8 warm-up reset",
            64'(pkt_bytes), 64'h0);
      end else if (q.size() == 0) begin
        chk(1'b0, "R3 unexpected packet", 64'(pkt_bytes), 64'h0);
      end else begin
        e = q.pop_front();
        chk(pkt_bytes == e.b && pkt_len == e.len, "R3/R5 packet",
            {29'h0, pkt_len, pkt_bytes}, {29'h0, e.len, e.b});
      end
    end
  end

  task automatic run_txn(input bit wr, input bit bm, input int cv,
                         input logic [7:0] d, input int bp, input bit pw);
    @(negedge clk);
    op_write = wr; bit_mode = bm; cv_num = 11'(cv);
    wr_data = d; bit_sel = 3'(bp); pwr_phase = pw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    while (!done) @(negedge clk) #1;
  endtask

  task automatic inject_ack(input int k);
    wait (n_long == k);
    @(posedge clk);
    @(negedge clk);
    ack_in = 1'b1; ready_hold = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    @(negedge clk);
    ready_hold = 1'b0;
  endtask

  task automatic finish_txn(input string req, input bit exp_ack);
    chk(q.size() == 0, {req, " all packets sent"}, 64'(q.size()), 64'd0);
    chk(ack_seen == exp_ack, {req, " ack_seen"}, 64'(ack_seen), 64'(exp_ack));
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    #1;
    chk(!pkt_valid && !busy && !done && !ack_seen && !overcurrent,
        "R3 reset state", {59'h0, pkt_valid, busy, done, ack_seen, overcurrent}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: byte verify, stalling serializer (R9)
    tog_mode = 1'b1;
    push(3, 32'h0, 3'd3); push(5, mk(0, 0, 1, 8'h03, 0), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    run_txn(0, 0, 1, 8'h03, 0, 0);
    finish_txn("R3/R9 verify", 1'b0);

    // R4: byte write at top CV, with recovery run
    push(3, 32'h0, 3'd3); push(11, mk(1, 0, 1024, 8'hA5, 0), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    run_txn(1, 0, 1024, 8'hA5, 0, 0);
    finish_txn("R4 write", 1'b0);
    tog_mode = 1'b0;

    // R6/R7/R12: bit verify, acknowledge after third instruction packet
    push(3, 32'h0, 3'd3); push(4, mk(0, 1, 65, 8'h01, 3), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    fork
      run_txn(0, 1, 65, 8'h01, 3, 0);
      inject_ack(3);
    join
    finish_txn("R7 early end", 1'b1);
    repeat (5) @(negedge clk);
    #1;
    chk(ack_seen == 1'b1 && !busy, "R11 flag held", 64'(ack_seen), 64'd1);

    // R6: acknowledge before window opens is ignored
    push(3, 32'h0, 3'd3); push(5, mk(0, 0, 513, 8'h11, 0), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    fork
      run_txn(0, 0, 513, 8'h11, 0, 0);
      inject_ack(1);
    join
    finish_txn("R6 outside window", 1'b0);

    // R7/R12: bit write, acknowledge inside recovery
    push(3, 32'h0, 3'd3); push(8, mk(1, 1, 513, 8'h00, 7), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    fork
      run_txn(1, 1, 513, 8'h00, 7, 0);
      inject_ack(7);
    join
    finish_txn("R7 recovery cut", 1'b1);

    // R2/R8: warm-up with a brief fault inside settling time
    push(20, 32'h0, 3'd3); push(3, 32'h0, 3'd3);
    push(5, mk(0, 0, 8, 8'h80, 0), 3'd4); push(1, 32'h0, 3'd3);
    n_long = 0;
    fork
      run_txn(0, 0, 8, 8'h80, 0, 1);
      begin
        repeat (3) @(negedge clk);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        fault_in = 1'b0;
      end
    join
    finish_txn("R2 warm-up", 1'b0);
    chk(overcurrent == 1'b0, "R8 early fault ignored", 64'(overcurrent), 64'd0);

    // R8: sustained fault aborts
    loose = 1'b1;
    fault_in = 1'b1;
    t0 = $time;
    run_txn(1, 0, 3, 8'h44, 0, 1);
    chk(overcurrent == 1'b1, "R8 overcurrent", 64'(overcurrent), 64'd1);
    chk(($time - t0) / 8 >= FC, "R8 settling respected", 64'(($time - t0) / 8), 64'(FC));
    fault_in = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    chk(!pkt_valid && !busy && overcurrent, "R8/R11 aborted and held",
        {61'h0, pkt_valid, busy, overcurrent}, 64'h1);
    loose = 1'b0;

    // R10: out-of-range CV numbers
    n_acc = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cv_num = (k == 0) ? 11'd0 : 11'd1025;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      #1;
      chk(!busy && !pkt_valid && n_acc == 0, "R10 ignored start",
          {62'h0, busy, pkt_valid}, 64'h0);
    end

    report();
  end

endmodule